// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block builds the trigger line that a timer hands to the timers that follow it. A 4-bit mode register picks one source for that line. The sources are:

- a software generate strobe;
- the counter-enable level;
- the update event;
- the channel-1 capture/compare event;
- any one of six compare reference levels;
- a set of one-clock pulses made from the edges of compare references 4, 5 and 6.

The output is registered, so the trigger line always follows its source by one clock.

Edge detection compares each compare reference with a copy registered on the previous clock. That history register tracks all six references at all times, whatever the mode. As a result, switching modes never produces an edge that did not happen. The mode register is loaded through a write strobe and a data word. The new mode selects the source from the clock edge that follows the write.

Top module: `trig_out_sel`

## Requirements
- R1: While rst_ni is low, trig_o is 0 and the mode register holds 0. After reset, with no mode write, the output follows the software generate strobe.
- R2: Mode 0 drives trig_o from sw_gen_i.
- R3: Mode 1 drives trig_o from cnt_en_i.
- R4: Mode 2 drives trig_o from upd_evt_i.
- R5: Mode 3 drives trig_o high for one clock per cycle in which cc1_evt_i is high, including on back-to-back events.
- R6: Modes 4 to 9 drive trig_o from the level of compare reference 1 to 6 respectively. Reference k is bit k-1 of oc_ref_i.
- R7: Mode 10 pulses on any change of reference 4 (bit 3). Mode 11 pulses on any change of reference 6 (bit 5).
- R8: Mode 12 pulses on a rise of reference 4 or a rise of reference 6. Mode 13 pulses on a rise of reference 4 or a fall of reference 6.
- R9: Mode 14 pulses on a rise of reference 5 (bit 4) or a rise of reference 6. Mode 15 pulses on a rise of reference 5 or a fall of reference 6.
- R10: trig_o is registered. It reflects the inputs sampled at the previous rising clock edge and never changes combinationally with an input.
- R11: An edge is a difference between a reference and its value one clock earlier, tracked in every mode. Selecting an edge mode while the references are steady produces no pulse.
- R12: When mode_we_i is high at a clock edge, the mode register loads mode_wdata_i, and the new mode selects the source at the next edge. When mode_we_i is low, mode_wdata_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | New mode value |
| sw_gen_i | input | 1 | Software generate strobe |
| cnt_en_i | input | 1 | Counter-enable level |
| upd_evt_i | input | 1 | Update event |
| cc1_evt_i | input | 1 | Channel-1 capture/compare event |
| oc_ref_i | input | 6 | Compare reference levels; bit k-1 is reference k |
| trig_o | output | 1 | Trigger output |

## Verification
The hardest case to reach is a mode change that lands on an edge mode while a reference has just moved, or has long been steady. Only the history register decides whether a pulse appears, and that register cannot be seen at the ports. The stimulus toggles references while a level mode is selected. It then writes an edge mode during steady periods and during active ones. The random phase holds the references still for long stretches and rewrites the mode often, so that both orders occur many times.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int MODE_W   = 4;
  localparam int NUM_REFS = 6;

  typedef enum logic [MODE_W-1:0] {
    M_SWGEN    = 4'd0,
    M_CNTEN    = 4'd1,
    M_UPDATE   = 4'd2,
    M_CC1PULSE = 4'd3,
    M_REF1     = 4'd4,
    M_REF2     = 4'd5,
    M_REF3     = 4'd6,
    M_REF4     = 4'd7,
    M_REF5     = 4'd8,
    M_REF6     = 4'd9,
    M_BOTH4    = 4'd10,
    M_BOTH6    = 4'd11,
    M_R4_R6    = 4'd12,
    M_R4_F6    = 4'd13,
    M_R5_R6    = 4'd14,
    M_R5_F6    = 4'd15
  } trig_mode_e;

  typedef struct packed {
    logic sw_gen;
    logic cnt_en;
    logic upd_evt;
    logic cc1_evt;
  } trig_evt_t;
endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg
  import trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output trig_mode_e        mode_o
);
  trig_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= M_SWGEN;
    else if (we_i) mode_q <= trig_mode_e'(wdata_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/trig_edge_hist.sv
module trig_edge_hist #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ref_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] hist_q;

  // history runs in every mode so a mode switch sees only real edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= ref_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise_o[g] =  ref_i[g] & ~hist_q[g];
    assign fall_o[g] = ~ref_i[g] &  hist_q[g];
  end
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
  import trig_pkg::*;
(
  input  trig_mode_e          mode_i,
  input  trig_evt_t           evt_i,
  input  logic [NUM_REFS-1:0] ref_i,
  input  logic [NUM_REFS-1:0] rise_i,
  input  logic [NUM_REFS-1:0] fall_i,
  output logic                sel_o
);
  localparam int I4 = 3;
  localparam int I5 = 4;
  localparam int I6 = 5;

  always_comb begin
    unique case (mode_i)
      M_SWGEN:    sel_o = evt_i.sw_gen;
      M_CNTEN:    sel_o = evt_i.cnt_en;
      M_UPDATE:   sel_o = evt_i.upd_evt;
      M_CC1PULSE: sel_o = evt_i.cc1_evt;
      M_REF1:     sel_o = ref_i[0];
      M_REF2:     sel_o = ref_i[1];
      M_REF3:     sel_o = ref_i[2];
      M_REF4:     sel_o = ref_i[I4];
      M_REF5:     sel_o = ref_i[I5];
      M_REF6:     sel_o = ref_i[I6];
      M_BOTH4:    sel_o = rise_i[I4] | fall_i[I4];
      M_BOTH6:    sel_o = rise_i[I6] | fall_i[I6];
      M_R4_R6:    sel_o = rise_i[I4] | rise_i[I6];
      M_R4_F6:    sel_o = rise_i[I4] | fall_i[I6];
      M_R5_R6:    sel_o = rise_i[I5] | rise_i[I6];
      M_R5_F6:    sel_o = rise_i[I5] | fall_i[I6];
      default:    sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
  import trig_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_we_i,
  input  logic [MODE_W-1:0]   mode_wdata_i,
  input  logic                sw_gen_i,
  input  logic                cnt_en_i,
  input  logic                upd_evt_i,
  input  logic                cc1_evt_i,
  input  logic [NUM_REFS-1:0] oc_ref_i,
  output logic                trig_o
);
  trig_mode_e          mode_q;
  trig_evt_t           evt;
  logic [NUM_REFS-1:0] rise, fall;
  logic                sel;
  logic                trig_q;

  trig_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode_q)
  );

  trig_edge_hist #(.N(NUM_REFS)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (oc_ref_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign evt = '{sw_gen: sw_gen_i, cnt_en: cnt_en_i,
                 upd_evt: upd_evt_i, cc1_evt: cc1_evt_i};

  trig_src_mux u_mux (
    .mode_i (mode_q),
    .evt_i  (evt),
    .ref_i  (oc_ref_i),
    .rise_i (rise),
    .fall_i (fall),
    .sel_o  (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= sel;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/trig_out_sel_chk.sv
module trig_out_sel_chk
  import trig_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sw_gen_i,
  input logic                cnt_en_i,
  input logic                upd_evt_i,
  input logic                cc1_evt_i,
  input logic [NUM_REFS-1:0] oc_ref_i,
  input logic [MODE_W-1:0]   mode_q,
  input logic                trig_o
);
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> !trig_o);

  a_r2_swgen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd0) |=> trig_o == $past(sw_gen_i));

  a_r3_cnten: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd1) |=> trig_o == $past(cnt_en_i));

  a_r4_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd2) |=> trig_o == $past(upd_evt_i));

  a_r5_cc1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd3) |=> trig_o == $past(cc1_evt_i));

  a_r6_ref1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd4) |=> trig_o == $past(oc_ref_i[0]));

  a_r6_ref6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd9) |=> trig_o == $past(oc_ref_i[5]));

  a_r11_steady_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q >= 4'd10 && $past(rst_ni) && $stable(oc_ref_i)) |=> !trig_o);
endmodule

bind trig_out_sel trig_out_sel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_gen_i  (sw_gen_i),
  .cnt_en_i  (cnt_en_i),
  .upd_evt_i (upd_evt_i),
  .cc1_evt_i (cc1_evt_i),
  .oc_ref_i  (oc_ref_i),
  .mode_q    (mode_q),
  .trig_o    (trig_o)
);

// File: tb/trig_out_sel_tb.sv
module trig_out_sel_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [3:0] mode_wdata_i = '0;
  logic       sw_gen_i = 1'b0, cnt_en_i = 1'b0, upd_evt_i = 1'b0, cc1_evt_i = 1'b0;
  logic [5:0] oc_ref_i = '0;
  logic       trig_o;

  int checks = 0, failures = 0;
  bit done = 0;

  int    mdl_mode = 0;
  int    mdl_prev [6];
  int    exp_trig = 0;
  string exp_tag = "R1";

  always #2.5 clk_i = ~clk_i;

  trig_out_sel u_dut (.*);

  function automatic string tag_of(int m);
    if (m == 0) return "R2";
    if (m == 1) return "R3";
    if (m == 2) return "R4";
    if (m == 3) return "R5";
    if (m <= 9) return "R6";
    if (m <= 11) return "R7";
    if (m <= 13) return "R8";
    return "R9";
  endfunction

  // behavioural reference: reference k is at index k-1
  function automatic int model(int m, int sw, int en, int up, int cc, int refs [6]);
    int rs [6];
    int fl [6];
    for (int k = 0; k < 6; k++) begin
      rs[k] = (refs[k] == 1 && mdl_prev[k] == 0) ? 1 : 0;
      fl[k] = (refs[k] == 0 && mdl_prev[k] == 1) ? 1 : 0;
    end
    case (m)
      0: return sw;
      1: return en;
      2: return up;
      3: return cc;
      4, 5, 6, 7, 8, 9: return refs[m-4];
      10: return rs[3] | fl[3];
      11: return rs[5] | fl[5];
      12: return rs[3] | rs[5];
      13: return rs[3] | fl[5];
      14: return rs[4] | rs[5];
      default: return rs[4] | fl[5];
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: trig_o=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: compare previous prediction, drive new inputs, predict
  task automatic cyc(bit we, int wd, int sw, int en, int up, int cc, logic [5:0] r,
                     string tag = "");
    int refs [6];
    @(negedge clk_i);
    check(exp_tag, int'(trig_o), exp_trig);
    mode_we_i = we; mode_wdata_i = wd[3:0];
    sw_gen_i = sw[0]; cnt_en_i = en[0]; upd_evt_i = up[0]; cc1_evt_i = cc[0];
    oc_ref_i = r;
    for (int k = 0; k < 6; k++) refs[k] = int'(r[k]);
    exp_trig = model(mdl_mode, sw, en, up, cc, refs);
    exp_tag  = (tag == "") ? tag_of(mdl_mode) : tag;
    for (int k = 0; k < 6; k++) mdl_prev[k] = refs[k];
    if (we) mdl_mode = wd;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) mdl_prev[k] = 0;
    // R1: output low in reset, even with inputs active
    repeat (3) @(negedge clk_i);
    sw_gen_i = 1'b1; cnt_en_i = 1'b1;
    @(negedge clk_i);
    check("R1", int'(trig_o), 0);
    sw_gen_i = 1'b0; cnt_en_i = 1'b0;
    rst_ni = 1'b1;
    exp_trig = 0; exp_tag = "R1";
    // R1: default mode follows sw_gen
    cyc(0, 0, 1, 1, 1, 1, 6'h00, "R1");
    cyc(0, 0, 0, 1, 1, 1, 6'h3F, "R1");
    cyc(0, 0, 0, 0, 0, 0, 6'h00, "R1");
    // R12: data without strobe ignored
    cyc(0, 1, 0, 1, 0, 0, 6'h00, "R12");
    cyc(0, 0, 0, 1, 0, 0, 6'h00, "R12");
    // R12 + R3: write mode 1
    cyc(1, 1, 1, 0, 0, 0, 6'h00, "R12");
    cyc(0, 0, 0, 1, 0, 0, 6'h00, "R12");
    cyc(0, 0, 0, 0, 0, 0, 6'h00, "R3");
    // R10: no combinational path
    @(negedge clk_i);
    check(exp_tag, int'(trig_o), exp_trig);
    cnt_en_i = 1'b1;
    #1 check("R10", int'(trig_o), 0);
    exp_trig = 1; exp_tag = "R10";
    // R5: back-to-back capture events
    cyc(1, 3, 0, 0, 0, 0, 6'h00);
    cyc(0, 0, 0, 0, 0, 1, 6'h00, "R5");
    cyc(0, 0, 0, 0, 0, 1, 6'h00, "R5");
    cyc(0, 0, 0, 0, 0, 0, 6'h00, "R5");
    // R11: toggle ref4 in a level mode, then switch to edge mode while steady
    cyc(1, 2, 0, 0, 0, 0, 6'h08);
    cyc(0, 0, 0, 0, 0, 0, 6'h00);
    cyc(0, 0, 0, 0, 0, 0, 6'h28);
    cyc(1, 12, 0, 0, 0, 0, 6'h28, "R11");
    cyc(0, 0, 0, 0, 0, 0, 6'h28, "R11");
    cyc(1, 10, 0, 0, 0, 0, 6'h28, "R11");
    cyc(0, 0, 0, 0, 0, 0, 6'h28, "R11");
    cyc(0, 0, 0, 0, 0, 0, 6'h20, "R7");
    cyc(0, 0, 0, 0, 0, 0, 6'h20, "R7");
    cyc(1, 13, 0, 0, 0, 0, 6'h20, "R11");
    cyc(0, 0, 0, 0, 0, 0, 6'h00, "R8");
    cyc(0, 0, 0, 0, 0, 0, 6'h08, "R8");
    cyc(0, 0, 0, 0, 0, 0, 6'h08, "R8");
    // random sweep over all modes, references often steady
    for (int n = 0; n < 4000; n++) begin
      bit we;
      logic [5:0] r;
      we = ($urandom_range(0, 15) == 0);
      r = oc_ref_i;
      if ($urandom_range(0, 2) == 0) r[$urandom_range(0, 5)] ^= 1'b1;
      cyc(we, int'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
          int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
          int'($urandom_range(0, 1)), r);
    end
    @(negedge clk_i);
    check(exp_tag, int'(trig_o), exp_trig);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule